// File: doc/BRIEF.md
# Paced Block DMA Channel

This block runs a single DMA channel that copies 32-bit words from a source address to a destination address. It moves data in bursts of 2^N words. Each burst keeps the bus request raised until its last word is written. After a burst, a programmable interval timer with a prescaler holds the channel off the bus before the next burst of the same run. The source can be replaced by a constant fill word. Each side's address can step up, step down or stay put.

Configuration arrives on plain input ports, so the surrounding register file owns address decoding. Two load strobes copy the source and destination addresses into working registers. A set pulse enables the channel and a clear pulse disables it. A run is one pass of the per-run word count. It starts in one of two ways: at once when the channel is enabled in immediate mode, or on a pulse from the event line picked by the trigger-select input. In repeat mode the channel re-arms after every run. In the default mode it re-arms until a total word limit has been reached, and then it disables itself.

The controller is a state machine with these states:
- IDLE: disabled.
- ARMED: enabled and waiting for a trigger.
- START: reloads addresses and the run counter.
- REQ: requests the bus and waits for the grant.
- READ: source read.
- LATCH: read data captured.
- WRITE: destination write.
- GAP: interval wait between bursts.
- FINISH: end of run and interrupt.

The transitions are:
- IDLE→START on enable in immediate mode; IDLE→ARMED on enable otherwise.
- ARMED→START on the selected trigger; ARMED→IDLE on clear.
- START→FINISH when the run count is zero; START→REQ otherwise.
- REQ→READ on grant, or REQ→WRITE on grant when filling.
- READ→LATCH, then LATCH→WRITE.
- WRITE→FINISH on the last run word or when the total limit is hit.
- WRITE→GAP at the end of a burst.
- WRITE→READ or WRITE→WRITE for the next word inside a burst.
- GAP→REQ when the interval expires; GAP→IDLE on clear.
- FINISH→IDLE in immediate mode or when the limit was hit; FINISH→ARMED otherwise.

Top module: `pdma_channel`

## Requirements
- R1: After reset, busy, bus_req, bus_rd, bus_wr and irq are all 0.
- R2: A load strobe copies its address, with bits 1:0 forced to 0, into both the programmed and the working register of that side. Every bus address has bits 1:0 equal to 0.
- R3: Destination mode (cfg_dst_mode) works as follows: 0 adds 4 after each word, 1 subtracts 4, and 2 keeps the address unchanged.
- R4: Source mode (cfg_src_mode) uses the same codes 0/1/2 as the destination. Code 3 performs no read at all and writes cfg_fill_word for every word.
- R5: Each copied word is read at the source address, with bus_rdata sampled one cycle after bus_rd. It is then written at the destination address two cycles after the read. bus_rd and bus_wr are never high together, and no read is issued before bus_gnt.
- R6: A burst of 2^cfg_burst_log2 words is moved under one continuous bus_req. Inside a burst, the next read follows a write by exactly 1 cycle. bus_req only falls in the cycle after a write.
- R7: Between bursts of one run, the read that opens the next burst comes cfg_interval*D+3 cycles after the last write. D is 1, 4, 16 or 64 for cfg_prescale 0, 1, 2 or 3.
- R8: With cfg_immediate set, an enable transfers cfg_run_words words without any trigger and then clears busy.
- R9: With cfg_repeat set, each pulse on trig_lines[cfg_trig_sel] while armed transfers cfg_run_words words and busy stays 1. Pulses on other lines start nothing.
- R10: With neither mode bit set, each trigger moves cfg_run_words words. Once cfg_total_words words have been moved since the enable, the channel stops, even in the middle of a run, and clears busy.
- R11: At the start of each run, a set reload flag restores that side's working address to the programmed value. With the flag clear, the address continues from where the last run stopped.
- R12: At the end of every run, irq is high for exactly one cycle if cfg_irq_en is 1, and stays low if it is 0.
- R13: ctl_enable_clr while armed returns the channel to idle with busy 0, and later triggers start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_src_addr | input | ADDR_W | Source address to load |
| cfg_src_load | input | 1 | Strobe: latch source address |
| cfg_dst_addr | input | ADDR_W | Destination address to load |
| cfg_dst_load | input | 1 | Strobe: latch destination address |
| cfg_src_mode | input | 2 | Source step: 0 up, 1 down, 2 fixed, 3 fill |
| cfg_dst_mode | input | 2 | Destination step: 0 up, 1 down, 2 fixed |
| cfg_src_reload | input | 1 | Restore source address at each run start |
| cfg_dst_reload | input | 1 | Restore destination address at each run start |
| cfg_fill_word | input | DATA_W | Constant written in fill mode |
| cfg_burst_log2 | input | BLOG_W | Burst length is 2^value words |
| cfg_interval | input | IVL_W | Inter-burst interval in prescaled ticks |
| cfg_prescale | input | 2 | Tick divider 1/4/16/64 |
| cfg_run_words | input | RUN_W | Words per run |
| cfg_total_words | input | TOTAL_W | Total word limit in default mode |
| cfg_immediate | input | 1 | Start a run on enable |
| cfg_repeat | input | 1 | Re-arm after each run, no limit |
| cfg_irq_en | input | 1 | Pulse irq at end of run |
| cfg_trig_sel | input | log2(NUM_TRIG) | Selects the trigger line |
| ctl_enable_set | input | 1 | Enable pulse |
| ctl_enable_clr | input | 1 | Disable pulse (armed or gap) |
| trig_lines | input | NUM_TRIG | Event pulses |
| busy | output | 1 | Enable/busy status |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | ADDR_W | Word address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid the cycle after bus_rd |
| irq | output | 1 | One-cycle end-of-run pulse |

## Verification
The bound properties watch the bus on every cycle:
- reads and writes never overlap;
- every access is word-aligned and made under a request;
- the request drops only after a write, which keeps bursts whole;
- no read happens in fill mode;
- irq is a single-cycle pulse that occurs while busy.

The bench's scenarios are the only place where other behaviour shows. These are the exact address sequences for each step mode, the fill data, the inter-burst delay for each prescale setting, trigger selection, reload against continuation, and self-disable at the total limit, including when the limit falls mid-run.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ARMED, ST_START, ST_REQ, ST_READ,
        ST_LATCH, ST_WRITE, ST_GAP, ST_FINISH
    } chan_state_e;

    typedef enum logic [1:0] {
        AM_INC  = 2'd0,
        AM_DEC  = 2'd1,
        AM_HOLD = 2'd2,
        AM_NONE = 2'd3
    } addr_mode_e;

endpackage

// File: rtl/pdma_addr_unit.sv
module pdma_addr_unit #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic              prog_load,
    input  logic [1:0]        mode,
    input  logic              reload_now,
    input  logic              step,
    output logic [ADDR_W-1:0] work_addr
);
    import pdma_pkg::*;

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= '0;
            work_addr <= '0;
        end else if (prog_load) begin
            base_q    <= prog_addr & ALIGN_MASK;
            work_addr <= prog_addr & ALIGN_MASK;
        end else if (reload_now) begin
            work_addr <= base_q;
        end else if (step) begin
            unique case (addr_mode_e'(mode))
                AM_INC:  work_addr <= work_addr + WORD_BYTES;
                AM_DEC:  work_addr <= work_addr - WORD_BYTES;
                default: work_addr <= work_addr;
            endcase
        end
    end

endmodule

// File: rtl/pdma_pacer.sv
module pdma_pacer #(
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [IVL_W-1:0] interval,
    input  logic [1:0]       prescale,
    output logic             expired
);
    localparam int PRE_W = 6;

    logic [IVL_W-1:0] cnt_q;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] tick_mask;
    logic             tick;

    always_comb begin
        unique case (prescale)
            2'd0:    tick_mask = PRE_W'(0);
            2'd1:    tick_mask = PRE_W'(3);
            2'd2:    tick_mask = PRE_W'(15);
            default: tick_mask = PRE_W'(63);
        endcase
    end

    assign tick    = (pre_q & tick_mask) == tick_mask;
    assign expired = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else if (load) begin
            cnt_q <= interval;
            pre_q <= '0;
        end else if (run && !expired) begin
            pre_q <= pre_q + 1'b1;
            if (tick) cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
    import pdma_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int RUN_W    = 24,
    parameter int TOTAL_W  = 28,
    parameter int IVL_W    = 16,
    parameter int BLOG_W   = 4,
    parameter int NUM_TRIG = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           cfg_src_addr,
    input  logic                        cfg_src_load,
    input  logic [ADDR_W-1:0]           cfg_dst_addr,
    input  logic                        cfg_dst_load,
    input  logic [1:0]                  cfg_src_mode,
    input  logic [1:0]                  cfg_dst_mode,
    input  logic                        cfg_src_reload,
    input  logic                        cfg_dst_reload,
    input  logic [DATA_W-1:0]           cfg_fill_word,
    input  logic [BLOG_W-1:0]           cfg_burst_log2,
    input  logic [IVL_W-1:0]            cfg_interval,
    input  logic [1:0]                  cfg_prescale,
    input  logic [RUN_W-1:0]            cfg_run_words,
    input  logic [TOTAL_W-1:0]          cfg_total_words,
    input  logic                        cfg_immediate,
    input  logic                        cfg_repeat,
    input  logic                        cfg_irq_en,
    input  logic [$clog2(NUM_TRIG)-1:0] cfg_trig_sel,
    input  logic                        ctl_enable_set,
    input  logic                        ctl_enable_clr,
    input  logic [NUM_TRIG-1:0]         trig_lines,
    output logic                        busy,
    output logic                        bus_req,
    input  logic                        bus_gnt,
    output logic                        bus_rd,
    output logic                        bus_wr,
    output logic [ADDR_W-1:0]           bus_addr,
    output logic [DATA_W-1:0]           bus_wdata,
    input  logic [DATA_W-1:0]           bus_rdata,
    output logic                        irq
);
    localparam int BURST_W = 1 << BLOG_W;

    chan_state_e state_q, state_d;

    logic [RUN_W-1:0]   run_left_q;
    logic [BURST_W-1:0] burst_left_q;
    logic [TOTAL_W-1:0] moved_q;
    logic [DATA_W-1:0]  data_q;
    logic               limit_hit_q;
    logic [ADDR_W-1:0]  src_addr, dst_addr;
    logic               gap_done;
    logic               fill_mode, trig_hit, limit_now, last_of_run, last_of_burst;

    assign fill_mode     = (addr_mode_e'(cfg_src_mode) == AM_NONE);
    assign trig_hit      = trig_lines[cfg_trig_sel];
    assign last_of_run   = (run_left_q == RUN_W'(1));
    assign last_of_burst = (burst_left_q == BURST_W'(1));
    assign limit_now     = !cfg_immediate && !cfg_repeat &&
                           (TOTAL_W'(moved_q + 1'b1) == cfg_total_words);

    pdma_addr_unit #(.ADDR_W(ADDR_W)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_addr  (cfg_src_addr),
        .prog_load  (cfg_src_load),
        .mode       (cfg_src_mode),
        .reload_now (state_q == ST_START && cfg_src_reload),
        .step       (state_q == ST_WRITE),
        .work_addr  (src_addr)
    );

    pdma_addr_unit #(.ADDR_W(ADDR_W)) u_dst (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_addr  (cfg_dst_addr),
        .prog_load  (cfg_dst_load),
        .mode       (cfg_dst_mode),
        .reload_now (state_q == ST_START && cfg_dst_reload),
        .step       (state_q == ST_WRITE),
        .work_addr  (dst_addr)
    );

    pdma_pacer #(.IVL_W(IVL_W)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_WRITE),
        .run      (state_q == ST_GAP),
        .interval (cfg_interval),
        .prescale (cfg_prescale),
        .expired  (gap_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (ctl_enable_set) state_d = cfg_immediate ? ST_START : ST_ARMED;
            ST_ARMED:  if (ctl_enable_clr) state_d = ST_IDLE;
                       else if (trig_hit)  state_d = ST_START;
            ST_START:  state_d = (cfg_run_words == '0) ? ST_FINISH : ST_REQ;
            ST_REQ:    if (bus_gnt) state_d = fill_mode ? ST_WRITE : ST_READ;
            ST_READ:   state_d = ST_LATCH;
            ST_LATCH:  state_d = ST_WRITE;
            ST_WRITE:  if (limit_now || last_of_run) state_d = ST_FINISH;
                       else if (last_of_burst)       state_d = ST_GAP;
                       else                          state_d = fill_mode ? ST_WRITE : ST_READ;
            ST_GAP:    if (ctl_enable_clr) state_d = ST_IDLE;
                       else if (gap_done)  state_d = ST_REQ;
            ST_FINISH: if (cfg_immediate || (!cfg_repeat && limit_hit_q)) state_d = ST_IDLE;
                       else                                                 state_d = ST_ARMED;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Counters and data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_left_q   <= '0;
            burst_left_q <= '0;
            moved_q      <= '0;
            data_q       <= '0;
            limit_hit_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && ctl_enable_set) begin
                moved_q     <= '0;
                limit_hit_q <= 1'b0;
            end
            if (state_q == ST_START) run_left_q <= cfg_run_words;
            if (state_q == ST_REQ && bus_gnt)
                burst_left_q <= BURST_W'(1) << cfg_burst_log2;
            if (state_q == ST_LATCH) data_q <= bus_rdata;
            if (state_q == ST_WRITE) begin
                run_left_q   <= run_left_q - 1'b1;
                burst_left_q <= burst_left_q - 1'b1;
                moved_q      <= moved_q + 1'b1;
                limit_hit_q  <= limit_now;
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        bus_req   = (state_q == ST_REQ) || (state_q == ST_READ) ||
                    (state_q == ST_LATCH) || (state_q == ST_WRITE);
        bus_rd    = (state_q == ST_READ);
        bus_wr    = (state_q == ST_WRITE);
        bus_addr  = (state_q == ST_READ) ? src_addr : dst_addr;
        bus_wdata = fill_mode ? cfg_fill_word : data_q;
        irq       = (state_q == ST_FINISH) && cfg_irq_en;
    end

endmodule

// File: rtl/pdma_channel_chk.sv
module pdma_channel_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        cfg_src_mode,
    input logic              irq
);
    // R5
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R5
    access_under_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> bus_req);

    // R5
    read_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd) |-> $past(bus_gnt) || $past(bus_wr));

    // R2
    word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> (bus_addr[1:0] == 2'b00));

    // R6
    burst_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> $past(bus_wr));

    // R4
    fill_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_src_mode == 2'd3) |-> !bus_rd);

    // R12
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R12
    irq_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> busy);

endmodule

bind pdma_channel pdma_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .bus_req      (bus_req),
    .bus_gnt      (bus_gnt),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .cfg_src_mode (cfg_src_mode),
    .irq          (irq)
);

// File: tb/sim_pdma_channel.sv
`timescale 1ns/1ps
module sim_pdma_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] cfg_src_addr = '0, cfg_dst_addr = '0, cfg_fill_word = '0;
    logic        cfg_src_load = 0, cfg_dst_load = 0;
    logic [1:0]  cfg_src_mode = 0, cfg_dst_mode = 0, cfg_prescale = 0;
    logic        cfg_src_reload = 0, cfg_dst_reload = 0;
    logic [3:0]  cfg_burst_log2 = 0, cfg_trig_sel = 0;
    logic [15:0] cfg_interval = 0;
    logic [23:0] cfg_run_words = 0;
    logic [27:0] cfg_total_words = 0;
    logic        cfg_immediate = 0, cfg_repeat = 0, cfg_irq_en = 0;
    logic        ctl_enable_set = 0, ctl_enable_clr = 0;
    logic [15:0] trig_lines = '0;
    logic        busy, bus_req, bus_gnt, bus_rd, bus_wr, irq;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        gnt_en = 1'b1;

    assign bus_gnt = bus_req & gnt_en;

    pdma_channel u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_src_addr(cfg_src_addr), .cfg_src_load(cfg_src_load),
        .cfg_dst_addr(cfg_dst_addr), .cfg_dst_load(cfg_dst_load),
        .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
        .cfg_src_reload(cfg_src_reload), .cfg_dst_reload(cfg_dst_reload),
        .cfg_fill_word(cfg_fill_word), .cfg_burst_log2(cfg_burst_log2),
        .cfg_interval(cfg_interval), .cfg_prescale(cfg_prescale),
        .cfg_run_words(cfg_run_words), .cfg_total_words(cfg_total_words),
        .cfg_immediate(cfg_immediate), .cfg_repeat(cfg_repeat),
        .cfg_irq_en(cfg_irq_en), .cfg_trig_sel(cfg_trig_sel),
        .ctl_enable_set(ctl_enable_set), .ctl_enable_clr(ctl_enable_clr),
        .trig_lines(trig_lines), .busy(busy), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    typedef struct packed { logic [31:0] a; logic [31:0] d; } wr_item_t;
    wr_item_t exp_q[$];
    wr_item_t cur;

    int checks = 0, errors = 0;
    int cyc = 0, last_wr = -1, exp_gap = -1;
    int wr_cnt = 0, rd_cnt = 0, irq_cnt = 0;
    bit done = 0;

    function automatic logic [31:0] mdata(input logic [31:0] a);
        return {a[15:0] ^ 16'h3C5A, ~a[15:0]};
    endfunction

    function automatic logic [31:0] step_addr(input logic [31:0] a, input logic [1:0] m);
        if (m == 2'd0) return a + 32'd4;
        if (m == 2'd1) return a - 32'd4;
        return a;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory model: data valid the cycle after a read
    always @(posedge clk) if (bus_rd) bus_rdata <= mdata(bus_addr);

    // Monitor / scoreboard
    always @(negedge clk) if (rst_n) begin
        cyc++;
        if (irq) irq_cnt++;
        if (bus_rd) begin
            rd_cnt++;
            if (exp_gap >= 0 && last_wr >= 0)
                chk((cyc - last_wr) == exp_gap, "R6/R7", "read spacing",
                    32'(cyc - last_wr), 32'(exp_gap));
        end
        if (bus_wr) begin
            wr_cnt++;
            last_wr = cyc;
            if (exp_q.size() == 0) chk(0, "R5", "unexpected write", bus_addr, 32'hFFFFFFFF);
            else begin
                cur = exp_q.pop_front();
                chk(bus_addr == cur.a, "R3", "write address", bus_addr, cur.a);
                chk(bus_wdata == cur.d, "R4/R5", "write data", bus_wdata, cur.d);
            end
        end
    end

    task automatic expect_run(inout logic [31:0] s, inout logic [31:0] d,
                              input int n, input logic [31:0] fill);
        for (int i = 0; i < n; i++) begin
            wr_item_t w;
            w.a = d;
            w.d = (cfg_src_mode == 2'd3) ? fill : mdata(s);
            exp_q.push_back(w);
            s = step_addr(s, cfg_src_mode);
            d = step_addr(d, cfg_dst_mode);
        end
    endtask

    task automatic prog(input logic [31:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_src_addr = s; cfg_dst_addr = d; cfg_src_load = 1; cfg_dst_load = 1;
        @(negedge clk);
        cfg_src_load = 0; cfg_dst_load = 0;
    endtask

    task automatic pulse_en();
        @(negedge clk); ctl_enable_set = 1;
        @(negedge clk); ctl_enable_set = 0;
    endtask

    task automatic pulse_trig(input int line);
        @(negedge clk); trig_lines[line] = 1'b1;
        @(negedge clk); trig_lines = '0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    endtask

    task automatic wait_irqs(input int n);
        for (int i = 0; i < 2000 && irq_cnt < n; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] s, d;
        int w0, r0, i0;
        repeat (3) @(negedge clk);
        // R1
        chk({busy, bus_req, bus_rd, bus_wr, irq} == 5'b0, "R1", "outputs in reset",
            32'({busy, bus_req, bus_rd, bus_wr, irq}), 0);
        rst_n = 1;
        @(negedge clk);
        chk({busy, bus_req, irq} == 3'b0, "R1", "outputs after reset",
            32'({busy, bus_req, irq}), 0);

        // R8 / R2 / R3: immediate, increment both, held-off grant
        cfg_immediate = 1; cfg_irq_en = 1; cfg_run_words = 6; cfg_burst_log2 = 1;
        prog(32'h0000_1003, 32'h0000_2001);
        s = 32'h1000; d = 32'h2000;
        expect_run(s, d, 6, 0);
        gnt_en = 0; r0 = rd_cnt;
        pulse_en();
        repeat (5) @(negedge clk);
        chk(rd_cnt == r0 && busy, "R5", "no read before grant", 32'(rd_cnt - r0), 0);
        gnt_en = 1;
        wait_idle();
        chk(exp_q.size() == 0, "R8", "immediate run drained", 32'(exp_q.size()), 0);
        chk(wr_cnt == 6, "R8", "immediate word count", 32'(wr_cnt), 6);
        chk(!busy, "R8", "busy cleared", 32'(busy), 0);
        chk(irq_cnt == 1, "R12", "irq pulse count", 32'(irq_cnt), 1);

        // R3 / R4 decrement source, fixed destination, within-burst spacing
        cfg_src_mode = 1; cfg_dst_mode = 2; cfg_run_words = 3; cfg_burst_log2 = 2;
        prog(32'h3000, 32'h4000);
        s = 32'h3000; d = 32'h4000;
        expect_run(s, d, 3, 0);
        exp_gap = 1; last_wr = -1;
        pulse_en(); wait_idle();
        chk(exp_q.size() == 0, "R6", "dec/fixed run drained", 32'(exp_q.size()), 0);
        exp_gap = -1;

        // R4 fill, destination decrement, irq disabled
        cfg_src_mode = 3; cfg_dst_mode = 1; cfg_run_words = 5; cfg_burst_log2 = 3;
        cfg_fill_word = 32'hCAFE_F00D; cfg_irq_en = 0;
        prog(32'h3000, 32'h5000);
        s = 32'h3000; d = 32'h5000;
        expect_run(s, d, 5, cfg_fill_word);
        r0 = rd_cnt; i0 = irq_cnt;
        pulse_en(); wait_idle();
        chk(rd_cnt == r0, "R4", "fill issues no reads", 32'(rd_cnt - r0), 0);
        chk(exp_q.size() == 0, "R4", "fill run drained", 32'(exp_q.size()), 0);
        chk(irq_cnt == i0, "R12", "no irq when disabled", 32'(irq_cnt - i0), 0);

        // R7 pacing for three prescale settings
        cfg_src_mode = 0; cfg_dst_mode = 0; cfg_irq_en = 1; cfg_burst_log2 = 0;
        for (int k = 0; k < 3; k++) begin
            cfg_interval  = (k == 0) ? 16'd3 : (k == 1) ? 16'd2 : 16'd1;
            cfg_prescale  = (k == 0) ? 2'd1  : (k == 1) ? 2'd3  : 2'd2;
            cfg_run_words = 3;
            prog(32'h6000, 32'h7000);
            s = 32'h6000; d = 32'h7000;
            expect_run(s, d, 3, 0);
            exp_gap = (k == 0) ? 15 : (k == 1) ? 131 : 19;
            last_wr = -1;
            pulse_en(); wait_idle();
            chk(exp_q.size() == 0, "R7", "paced run drained", 32'(exp_q.size()), 0);
        end
        exp_gap = -1; cfg_interval = 0; cfg_prescale = 0;

        // R9 repeat mode with trigger selection, no reload
        cfg_immediate = 0; cfg_repeat = 1; cfg_trig_sel = 5;
        cfg_run_words = 2; cfg_burst_log2 = 1;
        prog(32'h8000, 32'h9000);
        s = 32'h8000; d = 32'h9000;
        w0 = wr_cnt;
        pulse_en();
        repeat (3) @(negedge clk);
        chk(busy && wr_cnt == w0, "R9", "armed without transfer", 32'(wr_cnt - w0), 0);
        pulse_trig(4);
        repeat (20) @(negedge clk);
        chk(wr_cnt == w0, "R9", "other line ignored", 32'(wr_cnt - w0), 0);
        expect_run(s, d, 2, 0);
        i0 = irq_cnt;
        pulse_trig(5); wait_irqs(i0 + 1);
        expect_run(s, d, 2, 0);
        pulse_trig(5); wait_irqs(i0 + 2);
        chk(exp_q.size() == 0, "R11", "continued addresses", 32'(exp_q.size()), 0);
        chk(busy, "R9", "stays busy after runs", 32'(busy), 1);

        // R13 clear while armed
        @(negedge clk); ctl_enable_clr = 1;
        @(negedge clk); ctl_enable_clr = 0;
        @(negedge clk);
        chk(!busy, "R13", "busy after clear", 32'(busy), 0);
        w0 = wr_cnt;
        pulse_trig(5);
        repeat (20) @(negedge clk);
        chk(wr_cnt == w0, "R13", "trigger after clear", 32'(wr_cnt - w0), 0);

        // R11 reload restores both addresses
        cfg_src_reload = 1; cfg_dst_reload = 1;
        prog(32'hA000, 32'hB000);
        pulse_en();
        i0 = irq_cnt;
        s = 32'hA000; d = 32'hB000; expect_run(s, d, 2, 0);
        pulse_trig(5); wait_irqs(i0 + 1);
        s = 32'hA000; d = 32'hB000; expect_run(s, d, 2, 0);
        pulse_trig(5); wait_irqs(i0 + 2);
        chk(exp_q.size() == 0, "R11", "reloaded addresses", 32'(exp_q.size()), 0);
        @(negedge clk); ctl_enable_clr = 1;
        @(negedge clk); ctl_enable_clr = 0;

        // R10 total limit stops mid-run
        cfg_src_reload = 0; cfg_dst_reload = 0; cfg_repeat = 0; cfg_trig_sel = 2;
        cfg_run_words = 3; cfg_total_words = 5;
        prog(32'hC000, 32'hD000);
        s = 32'hC000; d = 32'hD000;
        pulse_en();
        i0 = irq_cnt; w0 = wr_cnt;
        expect_run(s, d, 3, 0);
        pulse_trig(2); wait_irqs(i0 + 1);
        chk(busy && wr_cnt - w0 == 3, "R10", "first run, still enabled", 32'(wr_cnt - w0), 3);
        expect_run(s, d, 2, 0);
        pulse_trig(2); wait_irqs(i0 + 2);
        chk(wr_cnt - w0 == 5, "R10", "limit word count", 32'(wr_cnt - w0), 5);
        chk(!busy, "R10", "self-disabled", 32'(busy), 0);
        chk(exp_q.size() == 0, "R10", "limit run drained", 32'(exp_q.size()), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule